// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low Power Idle Sequencer

This block decides when the transmit side of an Ethernet MAC may switch to low power idle (LPI) and when it must return. Software programs two registers: a control/status word and a timer word. The sequencer enters LPI only when all of these hold: software allows it, the PHY link has been reported good for a programmed number of milliseconds, and the transmit queue is empty. It leaves LPI when software withdraws permission, or, in automatic mode, when a frame is waiting. After it stops sending the idle pattern, it holds transmission off for a programmed number of microseconds so that the link partner can wake.

A free-running prescaler derives microsecond and millisecond ticks from the core clock. It restarts from zero at reset, and its periods are set by parameters. Transmit entry and exit, and receive entry and exit taken from an input indication, are latched in four sticky status bits. Reading the control/status word clears these bits, and their OR drives an interrupt. While the path sits in LPI, the block can also request that the transmit clock be gated.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset, tx_lpi, tx_hold, clk_gate_req and irq are low, and both registers read as zero.
- R2: Register word 0 (reg_addr=0) holds these control bits, all readable: bit 16 enable, bit 17 link good, bit 18 automatic wake, bit 19 clock-gate enable. Bits 3:0 are read-only status. Word 1 holds the wake time in µs in bits 15:0 and the link-stable time in ms in bits 25:16. All other bits read as zero.
- R3: With enable set and the queue idle, LPI entry (tx_lpi rising) does not occur until ls+1 millisecond ticks have passed with link good. Counted from the first cycle after link good is written, tx_lpi is first seen high after between ls*M+2 and (ls+1)*M+1 cycles, where M is the number of clocks per ms.
- R4: When the link is already stable and enable is set, dropping tx_pending makes tx_lpi high two cycles later.
- R5: In automatic mode, tx_pending during LPI starts the exit. In the next cycle clk_gate_req is low while tx_lpi is still high. One cycle after that, tx_lpi is low and tx_hold is high.
- R6: After tx_lpi falls, tx_hold stays high for between wake*P+1 and (wake+1)*P cycles, where P is the number of clocks per µs.
- R7: With automatic wake clear, tx_pending does not end LPI. Clearing the enable bit forces the exit: tx_lpi is low two cycles after the write.
- R8: clk_gate_req is high only during LPI, before the exit starts, and only when clock-gate enable is set.
- R9: Status bit 0 records transmit LPI entry and bit 1 records transmit exit (tx_hold start). Bit 2 records a rise of rx_lpi and bit 3 records a fall of rx_lpi. These bits stay set until word 0 is read.
- R10: Reading word 0 returns the status and clears it at the same clock edge. irq is high exactly while any status bit is set.
- R11: Clearing link good restarts the link-stable count, so entry needs a full new stable interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (word 0 read clears status) |
| reg_addr | input | 1 | 0 = control/status, 1 = timer |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, combinational from reg_addr |
| tx_pending | input | 1 | transmit queue holds a frame |
| rx_lpi | input | 1 | receive path is in LPI |
| tx_lpi | output | 1 | transmit is sending the LPI pattern |
| tx_hold | output | 1 | normal transmission must not start |
| clk_gate_req | output | 1 | request to gate the transmit clock |
| irq | output | 1 | any status bit set |

## Verification
A register write or a read-clear takes effect at the edge that ends the strobe cycle, and status and irq show it in the next cycle. A change of tx_pending shows up on tx_lpi two cycles later. An exit request lowers clk_gate_req after one cycle and tx_lpi after two. The millisecond and microsecond waits depend on the free-running prescaler phase, so the bench measures them in whole cycles and checks them against a window one tick period wide, computed from the programmed counts. Stimulus is driven on the falling edge and every output is sampled on the falling edge, half a cycle after the register that drives it changes.

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl #(
  parameter int CLKS_PER_US = 50,
  parameter int US_PER_MS   = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pending,
  input  logic        rx_lpi,
  output logic        tx_lpi,
  output logic        tx_hold,
  output logic        clk_gate_req,
  output logic        irq
);
  localparam int WAKE_W = 16;
  localparam int LS_W   = 10;
  localparam int MS_W   = LS_W + 1;
  localparam int PRE_W  = $clog2(CLKS_PER_US + 1);
  localparam int MSP_W  = $clog2(US_PER_MS + 1);

  typedef enum logic [1:0] {S_ACT, S_LPI, S_UNG, S_WAKE} state_t;

  state_t state, nstate;
  logic [PRE_W-1:0]  pre;
  logic [MSP_W-1:0]  msp;
  logic [WAKE_W-1:0] wake_us, us_cnt;
  logic [LS_W-1:0]   ls_ms;
  logic [MS_W-1:0]   ms_cnt;
  logic lpi_en, link_ok, tx_auto, gate_en, idle_q, rx_q;
  logic [3:0] st, ev;

  wire wr_ctrl = reg_wr && !reg_addr;
  wire wr_tmr  = reg_wr && reg_addr;
  wire rd_ctrl = reg_rd && !reg_addr;
  wire unused_wdata = ^reg_wdata[31:26];

  wire us_tick = (pre == PRE_W'(CLKS_PER_US - 1));
  wire ms_tick = us_tick && (msp == MSP_W'(US_PER_MS - 1));
  wire link_stable = ms_cnt > {1'b0, ls_ms};
  wire wake_req = !lpi_en || (tx_auto && tx_pending);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0;
      msp <= '0;
    end else begin
      pre <= us_tick ? '0 : pre + 1'b1;
      if (us_tick) msp <= ms_tick ? '0 : msp + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {lpi_en, link_ok, tx_auto, gate_en} <= '0;
      wake_us <= '0;
      ls_ms   <= '0;
    end else begin
      if (wr_ctrl) {gate_en, tx_auto, link_ok, lpi_en} <= reg_wdata[19:16];
      if (wr_tmr) begin
        wake_us <= reg_wdata[15:0];
        ls_ms   <= reg_wdata[25:16];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ms_cnt <= '0;
    else if (!link_ok) ms_cnt <= '0;
    else if (ms_tick && !(&ms_cnt)) ms_cnt <= ms_cnt + 1'b1;

  always_comb begin
    nstate = state;
    case (state)
      S_ACT:  if (lpi_en && link_stable && !tx_pending && idle_q) nstate = S_LPI;
      S_LPI:  if (wake_req) nstate = S_UNG;
      S_UNG:  nstate = S_WAKE;
      S_WAKE: if (us_tick && us_cnt == wake_us) nstate = S_ACT;
      default: nstate = S_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_ACT;
      us_cnt <= '0;
      idle_q <= 1'b0;
      rx_q   <= 1'b0;
      st     <= '0;
    end else begin
      state  <= nstate;
      us_cnt <= (state != S_WAKE) ? '0 : (us_tick ? us_cnt + 1'b1 : us_cnt);
      idle_q <= !tx_pending;
      rx_q   <= rx_lpi;
      st     <= (rd_ctrl ? 4'b0 : st) | ev;
    end

  assign ev = {!rx_lpi && rx_q, rx_lpi && !rx_q, state == S_UNG,
               state == S_ACT && nstate == S_LPI};

  assign tx_lpi       = (state == S_LPI) || (state == S_UNG);
  assign tx_hold      = state != S_ACT;
  assign clk_gate_req = (state == S_LPI) && gate_en;
  assign irq          = |st;
  assign reg_rdata    = reg_addr ? {6'b0, ls_ms, wake_us}
                                 : {12'b0, gate_en, tx_auto, link_ok, lpi_en, 12'b0, st};

  p_entry_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_lpi) |-> $past(link_ok && (ms_cnt > {1'b0, ls_ms}) && idle_q));
  p_ungate_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LPI && wake_req) |=> (tx_lpi && !clk_gate_req));
  p_wake_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_hold) |-> $past(us_tick && us_cnt == wake_us));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ctrl |=> ((st & $past(st)) == $past(st)));
  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && ev == 4'b0) |=> (st == 4'b0));
endmodule

// File: tb/eee_lpi_ctrl_test.sv
module eee_lpi_ctrl_test;
  localparam int P = 2;
  localparam int U = 4;
  localparam int M = P * U;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_pending = 0, rx_lpi = 0;
  logic tx_lpi, tx_hold, clk_gate_req, irq;
  int errors = 0, checks = 0;

  eee_lpi_ctrl #(.CLKS_PER_US(P), .US_PER_MS(U)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pending(tx_pending),
    .rx_lpi(rx_lpi), .tx_lpi(tx_lpi), .tx_hold(tx_hold),
    .clk_gate_req(clk_gate_req), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input bit a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_cnt(input bit want_lpi, output int n);
    n = 0;
    while ((want_lpi ? !tx_lpi : tx_hold) && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({tx_lpi, tx_hold, clk_gate_req, irq} == 0, "R1 outputs", {tx_lpi, tx_hold, clk_gate_req, irq}, 0);
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(1, d); chk(d == 0, "R1 timer", d, 0);
    // R2 register layout
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk(d == 32'h03FF_FFFF, "R2 timer mask", d, 32'h03FF_FFFF);
    wr(1, 32'h0003_0005); rd(1, d); chk(d == 32'h0003_0005, "R2 timer fields", d, 32'h0003_0005);
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk(d == 32'h000F_0000, "R2 ctrl bits", d, 32'h000F_0000);
    wr(0, 0); wait_cnt(0, n); rd(0, d);

    // sweep link-stable and wake times, gating on/off
    for (int ls = 0; ls < 4; ls += (ls == 1 ? 2 : 1)) begin
      for (int wk = 0; wk < 5; wk += (wk == 1 ? 3 : 1)) begin
        bit g;
        g = ((ls + wk) % 2) == 1;
        wr(0, 0); wait_cnt(0, n); rd(0, d);
        wr(1, (ls << 16) | wk);
        wr(0, 32'h0007_0000 | (g ? 32'h0008_0000 : 0));
        wait_cnt(1, n);
        chk_rng("R3 link-stable wait", n, ls * M + 2, (ls + 1) * M + 1);
        chk(clk_gate_req == g, "R8 gate in LPI", clk_gate_req, g);
        chk(irq == 1, "R10 irq set", irq, 1);
        rd(0, d); chk(d[3:0] == 4'b0001, "R9 tx entry", d[3:0], 1);
        chk(irq == 0, "R10 irq cleared", irq, 0);
        tx_pending = 1;
        @(negedge clk);
        chk(tx_lpi == 1 && clk_gate_req == 0, "R5 gate drops first", {tx_lpi, clk_gate_req}, 2);
        @(negedge clk);
        chk(tx_lpi == 0 && tx_hold == 1, "R5 exit", {tx_lpi, tx_hold}, 1);
        chk(clk_gate_req == 0, "R8 gate off outside LPI", clk_gate_req, 0);
        wait_cnt(0, n);
        chk_rng("R6 wake wait", n, wk * P + 1, (wk + 1) * P);
        rd(0, d); chk(d[3:0] == 4'b0010, "R9 tx exit", d[3:0], 2);
        tx_pending = 0;
        @(negedge clk);
        chk(tx_lpi == 0, "R4 not yet", tx_lpi, 0);
        @(negedge clk);
        chk(tx_lpi == 1, "R4 re-entry", tx_lpi, 1);
      end
    end

    // R7 no automatic wake: pending ignored, enable clear forces exit
    wr(0, 0); wait_cnt(0, n); rd(0, d);
    wr(1, 32'h0000_0001);
    wr(0, 32'h0003_0000);
    wait_cnt(1, n);
    tx_pending = 1;
    for (int i = 0; i < 12; i++) @(negedge clk);
    chk(tx_lpi == 1 && tx_hold == 1, "R7 pending ignored", {tx_lpi, tx_hold}, 3);
    wr(0, 32'h0002_0000);
    chk(tx_lpi == 1, "R7 still in LPI", tx_lpi, 1);
    @(negedge clk); @(negedge clk);
    chk(tx_lpi == 0 && tx_hold == 1, "R7 forced exit", {tx_lpi, tx_hold}, 1);
    wait_cnt(0, n);
    chk_rng("R6 wake wait forced", n, P + 1, 2 * P);
    tx_pending = 0;

    // R11 link drop restarts stable count
    wr(0, 0); wait_cnt(0, n); rd(0, d);
    wr(1, 32'h0002_0000);
    wr(0, 32'h0007_0000);
    for (int i = 0; i < 12; i++) @(negedge clk);
    chk(tx_lpi == 0, "R11 early", tx_lpi, 0);
    wr(0, 32'h0005_0000);
    for (int i = 0; i < 40; i++) @(negedge clk);
    chk(tx_lpi == 0, "R11 link down no entry", tx_lpi, 0);
    wr(0, 32'h0007_0000);
    wait_cnt(1, n);
    chk_rng("R11 full interval", n, 2 * M + 2, 3 * M + 1);

    // R9/R10 receive events
    wr(0, 0); wait_cnt(0, n); rd(0, d);
    rx_lpi = 1;
    @(negedge clk);
    chk(irq == 1, "R10 irq rx", irq, 1);
    rd(0, d); chk(d[3:0] == 4'b0100, "R9 rx entry", d[3:0], 4);
    rx_lpi = 0;
    @(negedge clk);
    rd(0, d); chk(d[3:0] == 4'b1000, "R9 rx exit", d[3:0], 8);
    rd(0, d); chk(d[3:0] == 4'b0000, "R10 cleared", d[3:0], 0);
    chk(irq == 0, "R10 irq low", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule